// File: doc/BRIEF.md
# Masked interrupt priority selector

This block sits beside a processor core. Each cycle it looks at the set of pending asynchronous interrupt sources and picks the one with the highest priority whose masking conditions allow it through. It then drives a level interrupt request line to the core's fetch logic. The masking depends on several inputs:

- the core's state bits: external enable, hypervisor state and problem state;
- the partition control bits;
- an event-branch global enable;
- a resume-as-reset flag;
- a strap saying whether the core implements hypervisor mode.

While the core is halted, a wake-control bit decides how selection works. When the bit is set, an external wake filter decides which sources may wake the core. When it is clear, the normal selection runs with the external enable forced on.

The selected source is given as a one-hot vector. Both the vector and the request line are registered, so they follow the inputs one clock later. Taking the interrupt and clearing pending bits is left to the core.

Top module: `irq_prio_sel`

## Requirements
- R1: The effective enable is the external-enable input OR the resume-as-reset input. It is forced to 1 when the core is halted and wake control is 0.
- R2: The pending and output vectors use this bit order: bit0 machine check, bit1 hypervisor decrementer, bit2 virtualization, bit3 external, bit4 decrementer, bit5 privileged doorbell, bit6 hypervisor doorbell, bit7 performance monitor, bit8 event-branch. A lower index has higher priority. A pending machine check is selected with no masking, except during a filtered halt (R9).
- R3: The hypervisor decrementer (bit1) is eligible only when its enable is 1 and either the effective enable is 1 or the core is not in hypervisor state.
- R4: Virtualization (bit2) is eligible only when its own enable is 1 and either the effective enable is 1 or the core is not in hypervisor state.
- R5: External (bit3) is eligible in either of two cases. The first is when the effective enable is 1 and the core is not blocked, where blocked means the external-block bit is 1 while the core is in hypervisor state and not in problem state. The second is when the core has hypervisor mode, is not in hypervisor state, and the routing bit is 0.
- R6: Bits 4 to 8 are eligible only when the effective enable is 1. Among them, priority runs in the bit order of R2.
- R7: Event-branch (bit8) is eligible only when the core is in problem state and the event-branch global enable is 1.
- R8: The selection and request outputs change exactly one clock edge after an input change, and they hold steady while the inputs hold steady.
- R9: When the core is halted and wake control is 1, the selection is the lowest-index set bit of the wake filter vector, and the pending masks are bypassed.
- R10: While reset is active, both outputs are 0.
- R11: The selection is one-hot or zero, and the request line is 1 exactly when the selection is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 9 | Pending sources, bit order as in R2 |
| core_ee_i | input | 1 | Core external-enable bit |
| core_hv_i | input | 1 | Core in hypervisor state |
| core_pr_i | input | 1 | Core in problem state |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| hvirt_en_i | input | 1 | Virtualization interrupt enable |
| ext_block_i | input | 1 | Blocks external delivery to the hypervisor |
| ext_route_i | input | 1 | Routes external interrupts away from the partition when 1 |
| evb_ge_i | input | 1 | Event-branch global enable |
| resume_rst_i | input | 1 | Resume-as-reset flag |
| has_hv_i | input | 1 | Core implements hypervisor mode |
| halted_i | input | 1 | Core is halted |
| wake_ctl_i | input | 1 | Halted-state wake control |
| wake_sel_i | input | 9 | Wake filter result, same bit order |
| sel_o | output | 9 | One-hot selected source |
| irq_o | output | 1 | Level interrupt request |

## Verification
Some properties hold on every cycle and are checked continuously:

- the selection is one-hot or zero;
- a pending machine check wins one cycle later;
- any source in bits 4 to 8 is selected only while the effective enable was 1;
- an event-branch selection always had problem state and its global enable;
- the outputs stay still while the inputs stay still.

Other behaviour depends on particular combinations of state bits and is shown only by the bench scenarios. This covers the two external-delivery paths and the block condition, the hypervisor-state exemption for the two hypervisor sources, the resume-as-reset override, the forced enable in an unfiltered halt, and the wake-filter bypass.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NSRC    = 9;
  localparam int unsigned S_MCHK  = 0;
  localparam int unsigned S_HDEC  = 1;
  localparam int unsigned S_HVIRT = 2;
  localparam int unsigned S_EXT   = 3;
  localparam int unsigned S_DEC   = 4;
  localparam int unsigned S_PDBL  = 5;
  localparam int unsigned S_HDBL  = 6;
  localparam int unsigned S_PERF  = 7;
  localparam int unsigned S_EVB   = 8;
  // first source that needs the effective enable unconditionally
  localparam int unsigned S_GATED_LO = S_DEC;

  typedef struct packed {
    logic ee;
    logic hv;
    logic pr;
    logic hdec_en;
    logic hvirt_en;
    logic ext_block;
    logic ext_route;
    logic evb_ge;
    logic resume_rst;
    logic has_hv;
    logic halted;
    logic wake_ctl;
  } mask_ctl_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
  import irq_prio_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0] pend_i,
  input  mask_ctl_t    ctl_i,
  output logic         eff_ee_o,
  output logic [N-1:0] elig_o
);
  logic eff_ee;
  logic hv_ok;
  logic ext_blocked;

  always_comb begin
    eff_ee      = ctl_i.ee | ctl_i.resume_rst | (ctl_i.halted & ~ctl_i.wake_ctl);
    hv_ok       = eff_ee | ~ctl_i.hv;
    ext_blocked = ctl_i.ext_block & ctl_i.hv & ~ctl_i.pr;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    if (g == S_MCHK) begin : g_mchk
      assign elig_o[g] = pend_i[g];
    end else if (g == S_HDEC) begin : g_hdec
      assign elig_o[g] = pend_i[g] & ctl_i.hdec_en & hv_ok;
    end else if (g == S_HVIRT) begin : g_hvirt
      assign elig_o[g] = pend_i[g] & ctl_i.hvirt_en & hv_ok;
    end else if (g == S_EXT) begin : g_ext
      assign elig_o[g] = pend_i[g] &
                         ((eff_ee & ~ext_blocked) |
                          (ctl_i.has_hv & ~ctl_i.hv & ~ctl_i.ext_route));
    end else if (g == S_EVB) begin : g_evb
      assign elig_o[g] = pend_i[g] & eff_ee & ctl_i.pr & ctl_i.evb_ge;
    end else begin : g_gated
      assign elig_o[g] = pend_i[g] & eff_ee;
    end
  end

  assign eff_ee_o = eff_ee;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign gnt_o[g]     = req_i[g] & ~taken[g];
    assign taken[g + 1] = taken[g] | req_i[g];
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic            core_ee_i,
  input  logic            core_hv_i,
  input  logic            core_pr_i,
  input  logic            hdec_en_i,
  input  logic            hvirt_en_i,
  input  logic            ext_block_i,
  input  logic            ext_route_i,
  input  logic            evb_ge_i,
  input  logic            resume_rst_i,
  input  logic            has_hv_i,
  input  logic            halted_i,
  input  logic            wake_ctl_i,
  input  logic [NSRC-1:0] wake_sel_i,
  output logic [NSRC-1:0] sel_o,
  output logic            irq_o
);
  localparam int unsigned IN_W = 2 * NSRC + $bits(mask_ctl_t);

  logic            rst_n_s;
  mask_ctl_t       ctl;
  logic            eff_ee;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] sel_n, sel_q;
  logic            irq_n, irq_q;
  logic            upd_en;
  logic            filt_halt;
  logic            past_ok_q;
  logic [IN_W-1:0] in_bundle;

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    ctl.ee         = core_ee_i;
    ctl.hv         = core_hv_i;
    ctl.pr         = core_pr_i;
    ctl.hdec_en    = hdec_en_i;
    ctl.hvirt_en   = hvirt_en_i;
    ctl.ext_block  = ext_block_i;
    ctl.ext_route  = ext_route_i;
    ctl.evb_ge     = evb_ge_i;
    ctl.resume_rst = resume_rst_i;
    ctl.has_hv     = has_hv_i;
    ctl.halted     = halted_i;
    ctl.wake_ctl   = wake_ctl_i;
  end

  irq_mask_gate #(.N(NSRC)) u_gate (
    .pend_i   (pend_i),
    .ctl_i    (ctl),
    .eff_ee_o (eff_ee),
    .elig_o   (elig)
  );

  assign filt_halt = halted_i & wake_ctl_i;
  assign cand      = filt_halt ? wake_sel_i : elig;

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req_i (cand),
    .gnt_o (sel_n)
  );

  always_comb begin
    irq_n  = |cand;
    upd_en = (sel_n != sel_q) | (irq_n != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_q <= '0;
      irq_q <= 1'b0;
    end else if (upd_en) begin
      sel_q <= sel_n;
      irq_q <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) past_ok_q <= 1'b0;
    else          past_ok_q <= 1'b1;
  end

  assign sel_o     = sel_q;
  assign irq_o     = irq_q;
  assign in_bundle = {pend_i, wake_sel_i, ctl};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(sel_o) && (irq_o == (sel_o != '0))) else $error("sel/irq"); // R11

  AST_MCHK_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pend_i[S_MCHK] && !filt_halt) |=> sel_o[S_MCHK]) else $error("mchk"); // R2

  AST_GATED_NEEDS_EE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (past_ok_q && (sel_o[NSRC-1:S_GATED_LO] != '0) && !$past(filt_halt))
      |-> $past(eff_ee)) else $error("gated"); // R6

  AST_EVB_NEEDS_PR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (past_ok_q && sel_o[S_EVB] && !$past(filt_halt))
      |-> $past(core_pr_i && evb_ge_i)) else $error("evb"); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (past_ok_q && (in_bundle == $past(in_bundle))) |=> $stable({sel_o, irq_o}))
    else $error("stable"); // R8
endmodule

// File: tb/irq_prio_sel_tb_top.sv
module irq_prio_sel_tb_top;
  localparam int N = 9;

  typedef struct packed {
    logic [N-1:0] pend;
    logic ee, hv, pr, hdec_en, hvirt_en, xblk, xroute, ge, rst, hashv, halted, wctl;
    logic [N-1:0] wake;
    logic [N-1:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{pend:9'h001, exp:9'h001, default:'0},                                   // R2 no mask
    '{pend:9'h018, ee:1'b1, exp:9'h008, default:'0},                          // R5 ext over dec
    '{pend:9'h010, exp:9'h000, default:'0},                                   // R6 gated off
    '{pend:9'h090, ee:1'b1, exp:9'h010, default:'0},                          // R6 dec over perf
    '{pend:9'h002, ee:1'b1, exp:9'h000, default:'0},                          // R3 enable off
    '{pend:9'h002, hdec_en:1'b1, exp:9'h002, default:'0},                     // R3 non-hv
    '{pend:9'h002, hdec_en:1'b1, hv:1'b1, exp:9'h000, default:'0},            // R3 hv masked
    '{pend:9'h00C, hvirt_en:1'b1, ee:1'b1, hv:1'b1, exp:9'h004, default:'0},  // R4
    '{pend:9'h008, ee:1'b1, hv:1'b1, xblk:1'b1, exp:9'h000, default:'0},      // R5 blocked
    '{pend:9'h008, hashv:1'b1, exp:9'h008, default:'0},                       // R5 partition path
    '{pend:9'h008, hashv:1'b1, xroute:1'b1, exp:9'h000, default:'0},          // R5 routed away
    '{pend:9'h100, ee:1'b1, pr:1'b1, ge:1'b1, exp:9'h100, default:'0},        // R7 taken
    '{pend:9'h100, ee:1'b1, ge:1'b1, exp:9'h000, default:'0},                 // R7 no pr
    '{pend:9'h010, rst:1'b1, exp:9'h010, default:'0},                         // R1 resume flag
    '{pend:9'h060, ee:1'b1, exp:9'h020, default:'0},                          // R6 pdbl first
    '{pend:9'h0C0, ee:1'b1, exp:9'h040, default:'0},                          // R6 hdbl first
    '{pend:9'h010, halted:1'b1, exp:9'h010, default:'0},                      // R1 forced
    '{pend:9'h011, ee:1'b1, halted:1'b1, wctl:1'b1, wake:9'h018, exp:9'h008, default:'0}, // R9
    '{pend:9'h001, halted:1'b1, wctl:1'b1, exp:9'h000, default:'0}           // R9 bypass
  };

  logic clk = 1'b0;
  logic rst_n;
  vec_t cur;
  logic [N-1:0] sel;
  logic irq;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_prio_sel dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(cur.pend), .core_ee_i(cur.ee),
    .core_hv_i(cur.hv), .core_pr_i(cur.pr), .hdec_en_i(cur.hdec_en),
    .hvirt_en_i(cur.hvirt_en), .ext_block_i(cur.xblk), .ext_route_i(cur.xroute),
    .evb_ge_i(cur.ge), .resume_rst_i(cur.rst), .has_hv_i(cur.hashv),
    .halted_i(cur.halted), .wake_ctl_i(cur.wctl), .wake_sel_i(cur.wake),
    .sel_o(sel), .irq_o(irq)
  );

  task automatic check(input string req, input logic [N-1:0] exp_sel);
    n_run++;
    if (sel !== exp_sel || irq !== (exp_sel != '0)) begin
      n_fail++;
      $display("FAIL %s: sel=%h irq=%b expected sel=%h irq=%b",
               req, sel, irq, exp_sel, exp_sel != '0);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cur = '0;
    cur.pend = 9'h1FF;
    cur.ee = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", '0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", 9'h001);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cur = VEC[i];
      @(posedge clk);
      #1;
      check($sformatf("vector %0d", i), VEC[i].exp);
    end

    // R8: output holds one clock after a mask change, then updates
    @(negedge clk);
    cur = '0;
    cur.pend = 9'h010;
    @(posedge clk);
    #1;
    check("R8", '0);
    @(negedge clk);
    cur.ee = 1'b1;
    #1;
    check("R8", '0);
    @(posedge clk);
    #1;
    check("R8", 9'h010);
    repeat (4) @(posedge clk);
    #1;
    check("R8", 9'h010);
    // R11: dropping the pending bit clears the request
    @(negedge clk);
    cur.pend = '0;
    @(posedge clk);
    #1;
    check("R11", '0);
    // R1: resume flag alone lets perf through
    @(negedge clk);
    cur.ee = 1'b0;
    cur.rst = 1'b1;
    cur.pend = 9'h080;
    @(posedge clk);
    #1;
    check("R1", 9'h080);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule